// File: doc/BRIEF.md
# Watchdog Countdown Timer with Register Access

This block is a watchdog peripheral. A host programs it through a small address/data bus: it sets a start value, releases a halt bit, and must then write the reload register regularly. Each pulse on the `tick` enable counts the down-counter one step toward zero. A slow real-time source outside the block makes the tick, nominally every 0.6 s. To program N seconds, the host writes N×10/6 ticks.

A tick that finds the counter at zero is an expiry. The first expiry sets a timeout flag, gives a one-cycle interrupt and restarts the count. If a second expiry arrives while that flag is still set, the block sets a second-timeout flag and latches a request for a system reset. A separate no-reboot flag masks the reset request output. The halt bit stops counting altogether. Either control alone keeps the reset request inactive. All registers are 16 bits wide and decode inside a 32-byte window.

Top module: `wdog_timer`

## Requirements
- R1: After a synchronous active-low reset, the state is as follows. Count (0x00) reads 0x0004. Control (0x08) reads 0x0800, which means halted. No-reboot (0x0A) reads 0x0001. Start value (0x12) reads 0x0004. Both status registers read 0. `irq` and `rst_req` are 0.
- R2: Bit 11 of the control register at 0x08 is the halt bit, and all 16 bits read back as written. While halt is 1, ticks leave the count unchanged. While halt is 0, each tick lowers a non-zero count by one, and the new count is visible in the cycle after the tick.
- R3: Any write to 0x00 loads the count from the start value, whatever the write data. This load wins over a tick in the same cycle and also works while halted. A read of 0x00 returns the count in bits [9:0], and bits [15:10] read as 0.
- R4: Bits [9:0] of 0x12 hold the start value, and bits [15:10] are stored and read back. A write whose bits [9:0] are below 4 is ignored entirely. Writing 0x12 does not by itself change the count.
- R5: A tick while not halted, with no reload, that finds the count at 0 is an expiry. If the timeout flag (bit 3 of 0x04) is clear, the expiry sets it, reloads the count from the start value, and pulses `irq` high for exactly one cycle.
- R6: An expiry while the timeout flag is already set does three things. It sets the second-timeout flag (bit 1 of 0x06), latches the reset request, and reloads the count. It raises no `irq`.
- R7: The no-reboot flag is bit 0 of 0x0A. While it is 1, `rst_req` is 0 whatever the latched state is. When it is cleared, `rst_req` follows the latched request.
- R8: Once latched, the reset request stays latched until `rst_n` is asserted. Clearing status flags or reloading the count does not drop it.
- R9: The status flags are write-one-to-clear. Writing 1 to bit 3 of 0x04 clears the timeout flag, and writing 1 to bit 1 of 0x06 clears the second-timeout flag. Zero bits leave them unchanged. When an expiry sets a flag in the same cycle as a clear of that flag, the set wins.
- R10: Addresses outside the map read as 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle count enable from the external time base |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Byte offset within the register window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | One-cycle pulse on the first expiry |
| rst_req | output | 1 | Level request for a system reset |

## Verification
The assertions assume that `tick` and the bus inputs are known and stable around each clock edge, with `bus_addr` valid whenever `bus_wr` is high. The single-cycle interrupt property also relies on the start value being at least four, so two expiries can never fall on adjacent cycles. The stimulus drives every input at the falling edge. It draws write addresses from the mapped offsets plus two unmapped ones, and it keeps random start values small so that expiries happen often. It sets the halt and no-reboot bits only part of the time, so that the reset path is reached both masked and unmasked.

// File: rtl/wdog_pkg.sv
// Shared constants and register decode for the watchdog timer.
// Assumes a 32-byte register window addressed by byte offset.
package wdog_pkg;

    localparam int ADDR_W   = 5;
    localparam int HALT_BIT = 11;
    localparam int TMO_BIT  = 3;
    localparam int SEC_BIT  = 1;
    localparam int NRB_BIT  = 0;

    localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STS1   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STS2   = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_NRB    = 5'h0A;
    localparam logic [ADDR_W-1:0] OFS_START  = 5'h12;

    typedef enum logic [2:0] {
        SEL_RELOAD,
        SEL_STS1,
        SEL_STS2,
        SEL_CTRL,
        SEL_NRB,
        SEL_START,
        SEL_NONE
    } reg_sel_e;

    // Map a byte offset to the register it selects.
    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_RELOAD: decode = SEL_RELOAD;
            OFS_STS1:   decode = SEL_STS1;
            OFS_STS2:   decode = SEL_STS2;
            OFS_CTRL:   decode = SEL_CTRL;
            OFS_NRB:    decode = SEL_NRB;
            OFS_START:  decode = SEL_START;
            default:    decode = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wdog_regfile.sv
// Register decode, host-writable storage and read mux of the watchdog.
// Assumes bus_addr is valid whenever bus_wr is high; reads are combinational.
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 10,
    parameter int MIN_INIT = 4,
    parameter int RST_INIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              tmo,
    input  logic              sec,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              halt,
    output logic              noreboot,
    output logic [CNT_W-1:0]  init_val,
    output logic              reload_wr,
    output logic              clr_tmo,
    output logic              clr_sec
);

    localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'(1) << HALT_BIT;

    reg_sel_e          sel;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] start_q;
    logic              nrb_q;
    logic              start_legal;

    // Decode the address and form the write strobes.
    always_comb begin
        sel         = decode(bus_addr);
        reload_wr   = bus_wr && (sel == SEL_RELOAD);
        clr_tmo     = bus_wr && (sel == SEL_STS1) && bus_wdata[TMO_BIT];
        clr_sec     = bus_wr && (sel == SEL_STS2) && bus_wdata[SEC_BIT];
        start_legal = bus_wdata[CNT_W-1:0] >= CNT_W'(MIN_INIT);
    end

    // Hold the control word, the no-reboot flag and the start value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            nrb_q   <= 1'b1;
            start_q <= DATA_W'(RST_INIT);
        end else if (bus_wr) begin
            if (sel == SEL_CTRL)                 ctrl_q  <= bus_wdata;
            if (sel == SEL_NRB)                  nrb_q   <= bus_wdata[NRB_BIT];
            if (sel == SEL_START && start_legal) start_q <= bus_wdata;
        end
    end

    assign halt     = ctrl_q[HALT_BIT];
    assign noreboot = nrb_q;
    assign init_val = start_q[CNT_W-1:0];

    // Select the read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_RELOAD: bus_rdata = DATA_W'(cnt);
            SEL_STS1:   bus_rdata[TMO_BIT] = tmo;
            SEL_STS2:   bus_rdata[SEC_BIT] = sec;
            SEL_CTRL:   bus_rdata = ctrl_q;
            SEL_NRB:    bus_rdata[NRB_BIT] = nrb_q;
            SEL_START:  bus_rdata = start_q;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_counter.sv
// Down-counter with reload. Flags an expiry when a running tick finds zero.
// Assumes tick is a single-cycle enable; a reload outranks a tick.
module wdog_counter #(
    parameter int CNT_W    = 10,
    parameter int RST_INIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             halt,
    input  logic             reload,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    logic run;

    // Decide whether this cycle counts and whether it expires.
    always_comb begin
        run    = tick && !halt;
        expire = run && !reload && (cnt == '0);
    end

    // Reload, decrement or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= CNT_W'(RST_INIT);
        else if (reload || expire) cnt <= init_val;
        else if (run)             cnt <= cnt - CNT_W'(1);
    end

endmodule

// File: rtl/wdog_expiry.sv
// Two-stage expiry: the first expiry sets a flag and pulses irq; a second
// one while the flag is set latches a reset request, masked by no-reboot.
// Assumes expire never fires on two adjacent cycles.
module wdog_expiry (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_tmo,
    input  logic clr_sec,
    input  logic noreboot,
    output logic tmo,
    output logic sec,
    output logic irq,
    output logic rst_held,
    output logic rst_req
);

    logic first_hit;
    logic second_hit;

    // Classify the expiry by the current timeout flag.
    always_comb begin
        first_hit  = expire && !tmo;
        second_hit = expire && tmo;
    end

    // Update the status flags, the interrupt pulse and the reset latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo      <= 1'b0;
            sec      <= 1'b0;
            irq      <= 1'b0;
            rst_held <= 1'b0;
        end else begin
            irq <= first_hit;
            if (first_hit)    tmo <= 1'b1;
            else if (clr_tmo) tmo <= 1'b0;
            if (second_hit)   sec <= 1'b1;
            else if (clr_sec) sec <= 1'b0;
            if (second_hit)   rst_held <= 1'b1;
        end
    end

    assign rst_req = rst_held && !noreboot;

endmodule

// File: rtl/wdog_timer.sv
// Watchdog timer top: register file, down-counter and expiry logic.
// Assumes an external one-cycle tick and a simple write-strobe host bus.
module wdog_timer #(
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 10,
    parameter int MIN_INIT = 4,
    parameter int RST_INIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] init_val;
    logic             halt, noreboot, reload_wr, clr_tmo, clr_sec;
    logic             expire, tmo, sec, rst_held;

    wdog_regfile #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .MIN_INIT(MIN_INIT), .RST_INIT(RST_INIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cnt(cnt), .tmo(tmo), .sec(sec),
        .bus_rdata(bus_rdata), .halt(halt), .noreboot(noreboot),
        .init_val(init_val), .reload_wr(reload_wr),
        .clr_tmo(clr_tmo), .clr_sec(clr_sec)
    );

    wdog_counter #(.CNT_W(CNT_W), .RST_INIT(RST_INIT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt),
        .reload(reload_wr), .init_val(init_val), .cnt(cnt), .expire(expire)
    );

    wdog_expiry u_exp (
        .clk(clk), .rst_n(rst_n), .expire(expire), .clr_tmo(clr_tmo),
        .clr_sec(clr_sec), .noreboot(noreboot), .tmo(tmo), .sec(sec),
        .irq(irq), .rst_held(rst_held), .rst_req(rst_req)
    );

endmodule

// File: rtl/wdog_timer_chk.sv
// Property checker for the watchdog timer, attached to every instance by bind.
// Assumes inputs are known at each clock edge.
module wdog_timer_chk #(
    parameter int CNT_W    = 10,
    parameter int MIN_INIT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             reload_wr,
    input logic             halt,
    input logic             noreboot,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] init_val,
    input logic             tmo,
    input logic             sec,
    input logic             irq,
    input logic             rst_held,
    input logic             rst_req
);

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !reload_wr |=> $stable(cnt)); // R2
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !halt && !reload_wr && cnt != '0 |=> cnt == $past(cnt) - CNT_W'(1)); // R2
    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |=> cnt == $past(init_val)); // R3
    AST_START_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        init_val >= CNT_W'(MIN_INIT)); // R4
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R5
    AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec) |-> $past(tmo)); // R6
    AST_SECOND_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec) |-> rst_held); // R6
    AST_NOREBOOT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        noreboot |-> !rst_req); // R7
    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_held |=> rst_held); // R8

endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload_wr(reload_wr),
    .halt(halt), .noreboot(noreboot), .cnt(cnt), .init_val(init_val),
    .tmo(tmo), .sec(sec), .irq(irq), .rst_held(rst_held), .rst_req(rst_req)
);

// File: tb/wdog_timer_test.sv
`timescale 1ns/1ps
module wdog_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, rst_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Reference state, updated from the requirements.
    logic [9:0]  m_cnt;
    logic [15:0] m_start, m_ctrl;
    bit          m_nrb, m_tmo, m_sec, m_held, m_irq;

    always #2.5 clk = ~clk;

    wdog_timer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req)
    );

    function automatic logic [15:0] m_read(input logic [4:0] a);
        case (a)
            5'h00:   m_read = {6'b0, m_cnt};
            5'h04:   m_read = {12'b0, m_tmo, 3'b0};
            5'h06:   m_read = {14'b0, m_sec, 1'b0};
            5'h08:   m_read = m_ctrl;
            5'h0A:   m_read = {15'b0, m_nrb};
            5'h12:   m_read = m_start;
            default: m_read = 16'h0000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 10'd4; m_start = 16'h0004; m_ctrl = 16'h0800;
        m_nrb = 1'b1; m_tmo = 1'b0; m_sec = 1'b0; m_held = 1'b0; m_irq = 1'b0;
    endtask

    task automatic model_step(input bit wr, input logic [4:0] a, input logic [15:0] d, input bit tk);
        bit rl, run, ex;
        rl  = wr && (a == 5'h00);
        run = tk && !m_ctrl[11];
        ex  = run && !rl && (m_cnt == 10'd0);
        m_irq = ex && !m_tmo;
        if (ex && m_tmo) begin m_sec = 1'b1; m_held = 1'b1; end
        else if (wr && a == 5'h06 && d[1]) m_sec = 1'b0;
        if (ex && !m_tmo) m_tmo = 1'b1;
        else if (wr && a == 5'h04 && d[3]) m_tmo = 1'b0;
        if (rl || ex) m_cnt = m_start[9:0];
        else if (run) m_cnt = m_cnt - 10'd1;
        if (wr && a == 5'h08) m_ctrl = d;
        if (wr && a == 5'h0A) m_nrb = d[0];
        if (wr && a == 5'h12 && d[9:0] >= 10'd4) m_start = d;
    endtask

    // One clock: drive at the falling edge, model at the rising edge, check after.
    task automatic step(input bit wr, input logic [4:0] a, input logic [15:0] d, input bit tk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; tick = tk;
        @(posedge clk);
        model_step(wr, a, d, tk);
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
        chk("R5 irq pulse", {15'b0, irq}, {15'b0, m_irq});
        chk("R7 reset request", {15'b0, rst_req}, {15'b0, m_held && !m_nrb});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 5'h00, 16'h0, 1'b1);
    endtask

    task automatic rd_exp(input logic [4:0] a, input logic [15:0] exp, input string tag);
        bus_addr = a; #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic rd_model(input logic [4:0] a);
        bus_addr = a; #1;
        chk("R2/R3/R9 random readback", bus_rdata, m_read(a));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_wr = 1'b0; tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] addrs [8];
        addrs = '{5'h00, 5'h04, 5'h06, 5'h08, 5'h0A, 5'h12, 5'h1E, 5'h01};
        model_reset();
        do_reset();

        // R1 reset state
        rd_exp(5'h00, 16'h0004, "R1 count");
        rd_exp(5'h08, 16'h0800, "R1 halted");
        rd_exp(5'h0A, 16'h0001, "R1 noreboot");
        rd_exp(5'h12, 16'h0004, "R1 start value");
        rd_exp(5'h04, 16'h0000, "R1 status1");
        rd_exp(5'h06, 16'h0000, "R1 status2");
        chk("R1 irq low", {15'b0, irq}, 16'h0);
        chk("R1 rst_req low", {15'b0, rst_req}, 16'h0);

        // R2 halt and decrement
        ticks(3);
        rd_exp(5'h00, 16'h0004, "R2 halt freezes");
        step(1'b1, 5'h08, 16'h0000, 1'b0);
        rd_exp(5'h08, 16'h0000, "R2 halt readback");
        ticks(2);
        rd_exp(5'h00, 16'h0002, "R2 decrement");

        // R3 reload priority and while halted
        step(1'b1, 5'h00, 16'hBEEF, 1'b1);
        rd_exp(5'h00, 16'h0004, "R3 reload beats tick");
        step(1'b1, 5'h08, 16'h8801, 1'b0);
        rd_exp(5'h08, 16'h8801, "R2 exact readback");
        ticks(2);
        rd_exp(5'h00, 16'h0004, "R2 halted again");

        // R4 start value
        step(1'b1, 5'h12, 16'hFC10, 1'b0);
        rd_exp(5'h12, 16'hFC10, "R4 upper bits kept");
        rd_exp(5'h00, 16'h0004, "R4 write alone no reload");
        step(1'b1, 5'h00, 16'h0000, 1'b0);
        rd_exp(5'h00, 16'h0010, "R3 reload while halted");
        step(1'b1, 5'h12, 16'hFC03, 1'b0);
        rd_exp(5'h12, 16'hFC10, "R4 value 3 ignored");
        step(1'b1, 5'h12, 16'h0000, 1'b0);
        rd_exp(5'h12, 16'hFC10, "R4 value 0 ignored");
        step(1'b1, 5'h12, 16'h03FF, 1'b0);
        rd_exp(5'h12, 16'h03FF, "R4 max value");
        step(1'b1, 5'h12, 16'h0004, 1'b0);
        rd_exp(5'h12, 16'h0004, "R4 min legal value");

        // R10 unmapped
        rd_exp(5'h1E, 16'h0000, "R10 unmapped read");
        step(1'b1, 5'h1E, 16'hFFFF, 1'b0);
        rd_exp(5'h08, 16'h8801, "R10 write no effect ctrl");
        rd_exp(5'h12, 16'h0004, "R10 write no effect start");

        // R5 first expiry
        step(1'b1, 5'h08, 16'h0000, 1'b0);
        step(1'b1, 5'h00, 16'h0000, 1'b0);
        ticks(4);
        rd_exp(5'h00, 16'h0000, "R5 reached zero");
        ticks(1);
        chk("R5 irq high", {15'b0, irq}, 16'h1);
        rd_exp(5'h04, 16'h0008, "R5 timeout flag");
        rd_exp(5'h00, 16'h0004, "R5 reload on expiry");
        step(1'b0, 5'h00, 16'h0, 1'b0);
        chk("R5 irq one cycle", {15'b0, irq}, 16'h0);

        // R9 zero bits ignored, then R6/R7/R8
        step(1'b1, 5'h04, 16'hFFF7, 1'b0);
        rd_exp(5'h04, 16'h0008, "R9 zero bit keeps flag");
        ticks(5);
        chk("R6 no irq on second", {15'b0, irq}, 16'h0);
        rd_exp(5'h06, 16'h0002, "R6 second flag");
        chk("R7 masked by noreboot", {15'b0, rst_req}, 16'h0);
        step(1'b1, 5'h0A, 16'h0000, 1'b0);
        chk("R7 unmasked", {15'b0, rst_req}, 16'h1);
        step(1'b1, 5'h06, 16'h0003, 1'b0);
        rd_exp(5'h06, 16'h0000, "R9 clear second flag");
        step(1'b1, 5'h04, 16'h0008, 1'b0);
        rd_exp(5'h04, 16'h0000, "R9 clear timeout flag");
        step(1'b1, 5'h00, 16'h0000, 1'b0);
        chk("R8 request sticky", {15'b0, rst_req}, 16'h1);
        do_reset();
        chk("R8 cleared by reset", {15'b0, rst_req}, 16'h0);

        // R9 set wins over same-cycle clear
        step(1'b1, 5'h08, 16'h0000, 1'b0);
        ticks(4);
        step(1'b1, 5'h04, 16'h0008, 1'b1);
        rd_exp(5'h04, 16'h0008, "R9 set beats clear");

        // Constrained random phase
        do_reset();
        void'($urandom(32'd20513));
        for (int it = 0; it < 4000; it++) begin
            bit         wr, tk;
            logic [4:0]  a;
            logic [15:0] d;
            if ($urandom % 600 == 0) do_reset();
            tk = ($urandom % 3) != 0;
            wr = ($urandom % 8) == 0;
            a  = addrs[$urandom % 8];
            d  = 16'($urandom);
            if (a == 5'h08) d[11] = ($urandom % 4) == 0;
            if (a == 5'h12) d[9:0] = 10'($urandom % 12);
            if (a == 5'h0A) d[0] = ($urandom % 3) == 0;
            step(wr, a, d, tk);
            rd_model(addrs[$urandom % 8]);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule